// File: doc/BRIEF.md
# Paged Effective Address Generator

This block produces the 20-bit byte address used by a 16-bit processor for each memory access. It holds four 16-bit address registers, and each one has its own 4-bit page register. A page register is loaded through a port of its own, separate from the port that loads the address registers. The output address is formed combinationally from the register contents and from fields of the current instruction.

Three addressing forms are offered. The register-indirect form uses the selected register as it is, with its page register above it. The displacement form adds a 4-bit member index into address bits 1 to 4 only, and any carry out of that field is dropped. One register can then point at a structure of up to 16 words and the instruction picks the member. The zero-page form builds a short absolute address from a 7-bit instruction field and from part of the workspace register (register 1). The page and all higher bits of that address are zero. A byte/word input decides whether address bit 0 comes from the register or is held at zero.

Top module: `paged_ea_gen`

## Requirements
- R1: While reset is asserted (rst_ni low), all address registers and all page registers clear to zero. After reset, ea_o is 0 in the register-indirect form for every register.
- R2: When ar_we_i is high at a rising clock edge, address register ar_sel_i takes ar_data_i. ea_o shows the new value only after that edge.
- R3: When pg_we_i is high at a rising clock edge, page register pg_sel_i takes pg_data_i. A page write leaves every address register unchanged, and an address write leaves every page register unchanged.
- R4: With mode_i = 2'b00 (register indirect), ea_o[19:16] is the page of register reg_sel_i, ea_o[15:1] is bits 15:1 of that register, and disp_i has no effect.
- R5: With mode_i = 2'b01 (displacement), ea_o[4:1] = (reg[4:1] + disp_i) mod 16. ea_o[15:5] is reg[15:5] unchanged, with no carry, and ea_o[19:16] is the register's page.
- R6: In the indirect and displacement forms, ea_o[0] equals reg[0] when byte_i is 1 and is 0 when byte_i is 0.
- R7: With mode_i = 2'b10 (zero page), ea_o[4:1] = zp_i[3:0], ea_o[7:5] = zp_i[6:4], ea_o[11:8] = register 1 bits 11:8, and ea_o[19:12] and ea_o[0] are 0. reg_sel_i and byte_i have no effect.
- R8: The reserved code mode_i = 2'b11 behaves exactly as register indirect.
- R9: ea_o follows changes of mode_i, reg_sel_i, disp_i, zp_i and byte_i in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ar_we_i | input | 1 | Address register write enable |
| ar_sel_i | input | 2 | Address register write index |
| ar_data_i | input | 16 | Address register write data |
| pg_we_i | input | 1 | Page register write enable |
| pg_sel_i | input | 2 | Page register write index |
| pg_data_i | input | 4 | Page register write data |
| mode_i | input | 2 | Addressing form: 00 indirect, 01 displacement, 10 zero page, 11 as indirect |
| reg_sel_i | input | 2 | Register used by the indirect forms |
| disp_i | input | 4 | Member displacement in words |
| zp_i | input | 7 | Zero-page field from the instruction |
| byte_i | input | 1 | 1 for a byte access, 0 for a word access |
| ea_o | output | 20 | Byte address |

## Verification
The bench builds the block with its default parameters: four 16-bit registers, 4-bit pages, a 4-bit displacement and a 7-bit zero-page field. With these values the registers hold all-ones offsets, pages at 0xF and low fields at 0xF. This reaches the displacement wraparound at bit 4 and shows that bits 15:5 stay unchanged at their maximum. Register 1 is loaded with a non-zero workspace field so that its bits 11:8 show up in the zero-page result. The reserved mode code and the timing of register writes against the clock edge are also exercised.

// File: rtl/peag_pkg.sv
package peag_pkg;
  typedef enum logic [1:0] {
    EA_IND  = 2'b00,
    EA_DISP = 2'b01,
    EA_ZP   = 2'b10,
    EA_RSV  = 2'b11
  } ea_mode_e;
endpackage

// File: rtl/peag_regfile.sv
module peag_regfile #(
  parameter int N_REG = 4,
  parameter int OFF_W = 16,
  parameter int PG_W  = 4,
  localparam int SEL_W = $clog2(N_REG)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        ar_we_i,
  input  logic [SEL_W-1:0]            ar_sel_i,
  input  logic [OFF_W-1:0]            ar_data_i,
  input  logic                        pg_we_i,
  input  logic [SEL_W-1:0]            pg_sel_i,
  input  logic [PG_W-1:0]             pg_data_i,
  output logic [N_REG-1:0][OFF_W-1:0] areg_o,
  output logic [N_REG-1:0][PG_W-1:0]  page_o
);
  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    logic ar_hit, pg_hit;
    assign ar_hit = ar_we_i && (ar_sel_i == SEL_W'(g));
    assign pg_hit = pg_we_i && (pg_sel_i == SEL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     areg_o[g] <= '0;
      else if (ar_hit) areg_o[g] <= ar_data_i;
    end

    // page written separately from its address register
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     page_o[g] <= '0;
      else if (pg_hit) page_o[g] <= pg_data_i;
    end
  end
endmodule

// File: rtl/peag_disp_add.sv
module peag_disp_add #(
  parameter int OFF_W  = 16,
  parameter int DISP_W = 4
) (
  input  logic [OFF_W-1:0]  base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              byte_i,
  output logic [OFF_W-1:0]  off_o
);
  logic [DISP_W-1:0] field_sum;

  // sum confined to the member field; carry is dropped
  assign field_sum = base_i[DISP_W:1] + disp_i;

  always_comb begin
    off_o              = base_i;
    off_o[DISP_W:1]    = field_sum;
    off_o[0]           = byte_i & base_i[0];
  end
endmodule

// File: rtl/peag_zp_form.sv
module peag_zp_form #(
  parameter int OFF_W     = 16,
  parameter int DISP_W    = 4,
  parameter int ZP_W      = 7,
  parameter int WS_MSB    = 11,
  localparam int WS_LSB   = ZP_W + 1,
  localparam int WS_W     = WS_MSB - WS_LSB + 1
) (
  input  logic [ZP_W-1:0]  zp_i,
  input  logic [WS_W-1:0]  ws_i,
  output logic [OFF_W-1:0] off_o
);
  always_comb begin
    off_o                   = '0;
    off_o[DISP_W:1]         = zp_i[DISP_W-1:0];
    off_o[ZP_W:DISP_W+1]    = zp_i[ZP_W-1:DISP_W];
    off_o[WS_MSB:WS_LSB]    = ws_i;
  end
endmodule

// File: rtl/paged_ea_gen.sv
module paged_ea_gen
  import peag_pkg::*;
#(
  parameter int N_REG  = 4,
  parameter int OFF_W  = 16,
  parameter int PG_W   = 4,
  parameter int DISP_W = 4,
  parameter int ZP_W   = 7,
  parameter int WS_REG = 1,
  parameter int WS_MSB = 11,
  localparam int SEL_W = $clog2(N_REG),
  localparam int EA_W  = OFF_W + PG_W,
  localparam int WS_LSB = ZP_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ar_we_i,
  input  logic [SEL_W-1:0]  ar_sel_i,
  input  logic [OFF_W-1:0]  ar_data_i,
  input  logic              pg_we_i,
  input  logic [SEL_W-1:0]  pg_sel_i,
  input  logic [PG_W-1:0]   pg_data_i,
  input  logic [1:0]        mode_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [ZP_W-1:0]   zp_i,
  input  logic              byte_i,
  output logic [EA_W-1:0]   ea_o
);
  logic [N_REG-1:0][OFF_W-1:0] areg_q;
  logic [N_REG-1:0][PG_W-1:0]  page_q;
  logic [DISP_W-1:0]           disp_eff;
  logic [OFF_W-1:0]            ind_off, zp_off;
  ea_mode_e                    mode;

  assign mode = ea_mode_e'(mode_i);

  peag_regfile #(.N_REG(N_REG), .OFF_W(OFF_W), .PG_W(PG_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ar_we_i   (ar_we_i),
    .ar_sel_i  (ar_sel_i),
    .ar_data_i (ar_data_i),
    .pg_we_i   (pg_we_i),
    .pg_sel_i  (pg_sel_i),
    .pg_data_i (pg_data_i),
    .areg_o    (areg_q),
    .page_o    (page_q)
  );

  // plain indirect is the displacement path with a zero displacement
  assign disp_eff = (mode == EA_DISP) ? disp_i : '0;

  peag_disp_add #(.OFF_W(OFF_W), .DISP_W(DISP_W)) u_disp (
    .base_i (areg_q[reg_sel_i]),
    .disp_i (disp_eff),
    .byte_i (byte_i),
    .off_o  (ind_off)
  );

  peag_zp_form #(.OFF_W(OFF_W), .DISP_W(DISP_W), .ZP_W(ZP_W), .WS_MSB(WS_MSB)) u_zp (
    .zp_i  (zp_i),
    .ws_i  (areg_q[WS_REG][WS_MSB:WS_LSB]),
    .off_o (zp_off)
  );

  always_comb begin
    unique case (mode)
      EA_ZP:   ea_o = {{PG_W{1'b0}}, zp_off};
      default: ea_o = {page_q[reg_sel_i], ind_off};
    endcase
  end
endmodule

// File: rtl/paged_ea_gen_chk.sv
module paged_ea_gen_chk #(
  parameter int N_REG  = 4,
  parameter int OFF_W  = 16,
  parameter int PG_W   = 4,
  localparam int SEL_W = $clog2(N_REG),
  localparam int EA_W  = OFF_W + PG_W
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        ar_we_i,
  input logic [SEL_W-1:0]            ar_sel_i,
  input logic [OFF_W-1:0]            ar_data_i,
  input logic                        pg_we_i,
  input logic [SEL_W-1:0]            pg_sel_i,
  input logic [PG_W-1:0]             pg_data_i,
  input logic [1:0]                  mode_i,
  input logic [SEL_W-1:0]            reg_sel_i,
  input logic                        byte_i,
  input logic [EA_W-1:0]             ea_o,
  input logic [N_REG-1:0][OFF_W-1:0] areg_q,
  input logic [N_REG-1:0][PG_W-1:0]  page_q
);
  a_r2_areg_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_we_i |=> areg_q[$past(ar_sel_i)] == $past(ar_data_i));

  a_r3_page_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_we_i |=> page_q[$past(pg_sel_i)] == $past(pg_data_i));

  a_r3_areg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ar_we_i |=> $stable(areg_q));

  a_r3_page_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pg_we_i |=> $stable(page_q));

  a_r5_no_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01) |->
      (ea_o[OFF_W-1:5] == areg_q[reg_sel_i][OFF_W-1:5]) &&
      (ea_o[EA_W-1:OFF_W] == page_q[reg_sel_i]));

  a_r6_word_bit0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_i |-> !ea_o[0]);

  a_r7_zp_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10) |-> (ea_o[EA_W-1:12] == '0) && !ea_o[0]);
endmodule

bind paged_ea_gen paged_ea_gen_chk #(.N_REG(N_REG), .OFF_W(OFF_W), .PG_W(PG_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ar_we_i   (ar_we_i),
  .ar_sel_i  (ar_sel_i),
  .ar_data_i (ar_data_i),
  .pg_we_i   (pg_we_i),
  .pg_sel_i  (pg_sel_i),
  .pg_data_i (pg_data_i),
  .mode_i    (mode_i),
  .reg_sel_i (reg_sel_i),
  .byte_i    (byte_i),
  .ea_o      (ea_o),
  .areg_q    (areg_q),
  .page_q    (page_q)
);

// File: tb/tb_paged_ea_gen.sv
module tb_paged_ea_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ar_we_i = 1'b0;
  logic [1:0]  ar_sel_i = '0;
  logic [15:0] ar_data_i = '0;
  logic        pg_we_i = 1'b0;
  logic [1:0]  pg_sel_i = '0;
  logic [3:0]  pg_data_i = '0;
  logic [1:0]  mode_i = '0;
  logic [1:0]  reg_sel_i = '0;
  logic [3:0]  disp_i = '0;
  logic [6:0]  zp_i = '0;
  logic        byte_i = 1'b0;
  logic [19:0] ea_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  paged_ea_gen dut (.*);

  // {mode, sel, disp, zp, byte, expected ea}
  localparam int NV = 12;
  localparam logic [35:0] VEC [NV] = '{
    {2'b00, 2'd0, 4'h7, 7'h00, 1'b0, 20'h31234},  // R4 disp ignored
    {2'b00, 2'd2, 4'h0, 7'h00, 1'b1, 20'hFFFFF},  // R6 byte
    {2'b00, 2'd2, 4'h0, 7'h00, 1'b0, 20'hFFFFE},  // R6 word
    {2'b01, 2'd0, 4'h3, 7'h00, 1'b0, 20'h3123A},  // R5
    {2'b01, 2'd3, 4'h1, 7'h00, 1'b0, 20'h50000},  // R5 wrap
    {2'b01, 2'd2, 4'hF, 7'h00, 1'b1, 20'hFFFFD},  // R5 wrap at max
    {2'b01, 2'd1, 4'h0, 7'h00, 1'b1, 20'hA0ABE},  // R5 zero disp
    {2'b10, 2'd2, 4'h0, 7'h5B, 1'b1, 20'h00AB6},  // R7
    {2'b10, 2'd0, 4'h9, 7'h7F, 1'b0, 20'h00AFE},  // R7
    {2'b10, 2'd3, 4'h0, 7'h00, 1'b1, 20'h00A00},  // R7
    {2'b11, 2'd3, 4'h5, 7'h00, 1'b1, 20'h5001F},  // R8
    {2'b01, 2'd3, 4'h5, 7'h00, 1'b1, 20'h50009}   // R5
  };

  task automatic check(input string req, input logic [19:0] got, input logic [19:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: ea_o=%05h expected %05h", req, got, exp);
    end
  endtask

  task automatic wr_areg(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk_i);
    ar_we_i = 1'b1; ar_sel_i = s; ar_data_i = d;
    @(negedge clk_i);
    ar_we_i = 1'b0;
  endtask

  task automatic wr_page(input logic [1:0] s, input logic [3:0] d);
    @(negedge clk_i);
    pg_we_i = 1'b1; pg_sel_i = s; pg_data_i = d;
    @(negedge clk_i);
    pg_we_i = 1'b0;
  endtask

  task automatic apply(input logic [1:0] m, input logic [1:0] s, input logic [3:0] d,
                       input logic [6:0] z, input logic b);
    mode_i = m; reg_sel_i = s; disp_i = d; zp_i = z; byte_i = b;
    #0.5;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state, both during and after reset
    for (int i = 0; i < 4; i++) begin
      apply(2'b00, 2'(i), 4'h0, 7'h00, 1'b1);
      check("R1", ea_o, 20'h0);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    apply(2'b01, 2'd2, 4'h0, 7'h00, 1'b1);
    check("R1", ea_o, 20'h0);

    // R2 write timing: not visible before the edge
    @(negedge clk_i);
    apply(2'b00, 2'd0, 4'h0, 7'h00, 1'b0);
    ar_we_i = 1'b1; ar_sel_i = 2'd0; ar_data_i = 16'h1234;
    #0.5;
    check("R2", ea_o, 20'h00000);
    @(negedge clk_i);
    ar_we_i = 1'b0;
    check("R2", ea_o, 20'h01234);

    wr_areg(2'd1, 16'h0ABE);
    wr_areg(2'd2, 16'hFFFF);
    wr_areg(2'd3, 16'h001F);

    // R3 page write leaves address register alone
    wr_page(2'd0, 4'h3);
    apply(2'b00, 2'd0, 4'h0, 7'h00, 1'b0);
    check("R3", ea_o, 20'h31234);
    wr_page(2'd1, 4'hA);
    wr_page(2'd2, 4'hF);
    wr_page(2'd3, 4'h5);
    // R3 address write leaves page alone
    wr_areg(2'd0, 16'h4000);
    apply(2'b00, 2'd0, 4'h0, 7'h00, 1'b0);
    check("R3", ea_o, 20'h34000);
    wr_areg(2'd0, 16'h1234);

    @(negedge clk_i);
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][35:34], VEC[v][33:32], VEC[v][31:28], VEC[v][27:21], VEC[v][20]);
      check($sformatf("vector %0d (R4-R8 table)", v), ea_o, VEC[v][19:0]);
    end

    // R9 same-cycle response, no clock edge between changes
    @(negedge clk_i);
    apply(2'b00, 2'd0, 4'h0, 7'h00, 1'b0);
    check("R9", ea_o, 20'h31234);
    apply(2'b00, 2'd1, 4'h0, 7'h00, 1'b0);
    check("R9", ea_o, 20'hA0ABE);
    apply(2'b10, 2'd1, 4'h0, 7'h01, 1'b0);
    check("R9", ea_o, 20'h00A02);

    // R7 workspace bits follow register 1
    wr_areg(2'd1, 16'h0F00);
    apply(2'b10, 2'd2, 4'h0, 7'h00, 1'b1);
    check("R7", ea_o, 20'h00F00);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: done=0 expected 1");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule